// File: doc/BRIEF.md
# Cache Hit and Permission Checker

This block serves one processor access at a time against a small set-associative cache. It holds the tag, line-state and data arrays. For each request it compares the tag in every way of the indexed set at once. It then decides whether the matched line grants the access. It answers with hit or miss, the bytes read, a latency figure and a group of completion flags. Each line carries six state bits: valid, writable, dirty, prefetched, compressed and reserved. A write hit merges its bytes into the line. A locked read places a reservation on the line, and a locked write acts as a store-conditional against that reservation.

Lines enter the arrays through an install port. That port is driven by the miss/refill engine, which lies outside this block, together with replacement and coherence. The data itself is stored uncompressed. The compressed flag only adds decompression time to the hit latency.

Control is a three-state machine, written `ST_IDLE`, `ST_LOOK` and `ST_RESP`. It has four transitions:
- `ST_IDLE` stays in `ST_IDLE` while no request is accepted. An install is taken only here.
- `ST_IDLE` goes to `ST_LOOK` when a request is accepted. The request is captured on that edge.
- `ST_LOOK` always goes to `ST_RESP`. The lookup is evaluated in `ST_LOOK`, and on that edge the response is registered and the line is updated.
- `ST_RESP` always goes back to `ST_IDLE`. The response is presented during `ST_RESP`.

Top module: `cache_hit_check`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid` is 0. Every line is invalid, so any access misses.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is low for the next two cycles. `resp_valid` is high for exactly one cycle, starting with the second rising edge after acceptance.
- R3: Address layout, from low to high: the offset is the low log2(BLK_BYTES) bits, then log2(SETS) set bits, then the tag. `req_size` code 0, 1 or 2 selects 1, 2 or 4 bytes. A read hits when the tag matches a valid line in the set; if several ways match, the lowest-numbered one is used. `resp_rdata` byte i is line byte (offset+i) for i below the size, and zero above it. On a miss or a write, `resp_rdata` is zero.
- R4: A write hits only when the matched line is writable. A write to a valid line that is not writable is reported as a miss with `resp_satisfied` 0, and the line data is left unchanged.
- R5: A write hit that performs its store copies the request bytes into the line at the offset and sets the dirty bit. `resp_dirty` shows the line's dirty bit after the access on a hit, and is 0 on a miss.
- R6: `resp_lat` equals HIT_LAT, plus DECOMP_LAT/4 when the access hits a line whose compressed flag is set.
- R7: A hit on a line flagged prefetched clears that flag. When TRAIN_ON_MISS is 1, `resp_pf_notify` is 1 in that response. Later hits on the same line do not notify.
- R8: A locked write (store-conditional) that matches no line completes at once. It reports `resp_satisfied` 1, `resp_hit` 0 and `resp_sc_ok` 0, and no line changes.
- R9: A locked read hit sets the line's reservation. A store-conditional that hits a reserved line stores its bytes, reports `resp_sc_ok` 1 and clears the reservation.
- R10: Any performed write hit clears the line's reservation. A store-conditional that hits a line with no reservation reports `resp_hit` 1 and `resp_sc_ok` 0, and stores nothing.
- R11: An access with size code 3, or whose offset plus byte count exceeds BLK_BYTES, is a miss. It reports `resp_range_err` 1 and `resp_satisfied` 0, and changes no line.
- R12: When `inst_valid` is 1 in `ST_IDLE`, the addressed set/way is loaded with the tag, data and the writable, prefetched and compressed flags, and is marked valid, clean and unreserved. `req_ready` is 0 in any cycle with `inst_valid` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Size code: 0/1/2 = 1/2/4 bytes, 3 invalid |
| req_locked | input | 1 | Locked access: load-linked on read, store-conditional on write |
| req_wdata | input | ACC_BYTES*8 | Write bytes, byte 0 lowest |
| inst_valid | input | 1 | Install a line |
| inst_set | input | IDX_W | Install set |
| inst_way | input | WAY_W | Install way |
| inst_tag | input | TAG_W | Install tag |
| inst_writable | input | 1 | Installed line grants writes |
| inst_prefetched | input | 1 | Installed line came from a prefetch |
| inst_compressed | input | 1 | Installed line is held compressed |
| inst_data | input | BLK_BYTES*8 | Line bytes, byte 0 lowest |
| resp_valid | output | 1 | Response strobe |
| resp_hit | output | 1 | Access hit with permission |
| resp_satisfied | output | 1 | Access completed without a refill |
| resp_sc_ok | output | 1 | Store-conditional succeeded |
| resp_range_err | output | 1 | Offset/size out of range |
| resp_pf_notify | output | 1 | Prefetcher notification |
| resp_dirty | output | 1 | Line dirty bit after the access |
| resp_lat | output | LAT_W | Hit latency in cycles |
| resp_rdata | output | ACC_BYTES*8 | Read bytes |

## Verification
Directed cases first cover each kind of access against each kind of line state: reads at aligned and unaligned offsets of every size, writes to read-only and writable lines, and offsets that run just inside or just past the line end. These show whether permission, range and byte placement are decided separately. Paired sequences then separate the reservation rules from plain write hits: a load-linked read followed by a store-conditional, a repeated store-conditional, and a plain store placed between them. Repeated hits on prefetched and compressed lines show whether the flags are one-shot or sticky. A seeded random mix of installs and accesses over a small tag pool then makes hits, aliases, permission misses and reservation hazards collide in orders the directed cases do not reach.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

    typedef struct packed {
        logic valid;
        logic writable;
        logic dirty;
        logic pref;
        logic comp;
        logic resv;
    } line_flags_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_RESP = 2'd2
    } ctl_state_t;

endpackage

// File: rtl/hpc_way_match.sv
module hpc_way_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 11,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0]            way_valid,
    input  logic [TAG_W-1:0]           look_tag,
    output logic                       any_match,
    output logic [WAY_W-1:0]           sel_way
);

    logic [WAYS-1:0] eq;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign eq[w] = way_valid[w] && (way_tag[w] == look_tag);
        end
    endgenerate

    // Lowest-numbered matching way wins.
    always_comb begin
        sel_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (eq[w]) sel_way = WAY_W'(w);
        end
    end

    assign any_match = |eq;

endmodule

// File: rtl/hpc_line_store.sv
module hpc_line_store
    import hpc_pkg::*;
#(
    parameter int SETS      = 4,
    parameter int WAYS      = 2,
    parameter int TAG_W     = 11,
    parameter int BLK_BYTES = 8,
    parameter int IDX_W     = 2,
    parameter int WAY_W     = 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              inst_en,
    input  logic [IDX_W-1:0]                  inst_set,
    input  logic [WAY_W-1:0]                  inst_way,
    input  logic [TAG_W-1:0]                  inst_tag,
    input  line_flags_t                       inst_flags,
    input  logic [BLK_BYTES*8-1:0]            inst_data,
    input  logic                              upd_en,
    input  logic [IDX_W-1:0]                  upd_set,
    input  logic [WAY_W-1:0]                  upd_way,
    input  line_flags_t                       upd_flags,
    input  logic [BLK_BYTES*8-1:0]            upd_data,
    input  logic [IDX_W-1:0]                  rd_set,
    output logic [WAYS-1:0][TAG_W-1:0]        rd_tag,
    output line_flags_t [WAYS-1:0]            rd_flags,
    output logic [WAYS-1:0][BLK_BYTES*8-1:0]  rd_data
);

    logic [TAG_W-1:0]       tag_q  [SETS][WAYS];
    line_flags_t            flg_q  [SETS][WAYS];
    logic [BLK_BYTES*8-1:0] dat_q  [SETS][WAYS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    flg_q[s][w] <= '0;
                end
            end
        end else if (inst_en) begin
            flg_q[inst_set][inst_way] <= inst_flags;
        end else if (upd_en) begin
            flg_q[upd_set][upd_way] <= upd_flags;
        end
    end

    always_ff @(posedge clk) begin
        if (inst_en) begin
            tag_q[inst_set][inst_way] <= inst_tag;
            dat_q[inst_set][inst_way] <= inst_data;
        end else if (upd_en) begin
            dat_q[upd_set][upd_way] <= upd_data;
        end
    end

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            rd_tag[w]   = tag_q[rd_set][w];
            rd_flags[w] = flg_q[rd_set][w];
            rd_data[w]  = dat_q[rd_set][w];
        end
    end

endmodule

// File: rtl/hpc_byte_lane.sv
module hpc_byte_lane #(
    parameter int BLK_BYTES = 8,
    parameter int ACC_BYTES = 4,
    parameter int OFF_W     = 3
) (
    input  logic [BLK_BYTES*8-1:0] line,
    input  logic [OFF_W-1:0]       off,
    input  logic [OFF_W+1:0]       nbytes,
    input  logic [ACC_BYTES*8-1:0] wdata,
    output logic [ACC_BYTES*8-1:0] rdata,
    output logic [BLK_BYTES*8-1:0] merged
);

    always_comb begin
        rdata = '0;
        for (int i = 0; i < ACC_BYTES; i++) begin
            if (i < int'(nbytes) && (int'(off) + i) < BLK_BYTES) begin
                rdata[i*8 +: 8] = line[(int'(off) + i)*8 +: 8];
            end
        end
    end

    always_comb begin
        merged = line;
        for (int j = 0; j < BLK_BYTES; j++) begin
            if (j >= int'(off) && j < int'(off) + int'(nbytes) &&
                (j - int'(off)) < ACC_BYTES) begin
                merged[j*8 +: 8] = wdata[(j - int'(off))*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/cache_hit_check.sv
module cache_hit_check
    import hpc_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int SETS          = 4,
    parameter int WAYS          = 2,
    parameter int BLK_BYTES     = 8,
    parameter int ACC_BYTES     = 4,
    parameter int HIT_LAT       = 2,
    parameter int DECOMP_LAT    = 8,
    parameter int LAT_W         = 8,
    parameter bit TRAIN_ON_MISS = 1'b1,
    localparam int OFF_W        = $clog2(BLK_BYTES),
    localparam int IDX_W        = $clog2(SETS),
    localparam int TAG_W        = ADDR_W - OFF_W - IDX_W,
    localparam int WAY_W        = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic                   req_write,
    input  logic [1:0]             req_size,
    input  logic                   req_locked,
    input  logic [ACC_BYTES*8-1:0] req_wdata,
    input  logic                   inst_valid,
    input  logic [IDX_W-1:0]       inst_set,
    input  logic [WAY_W-1:0]       inst_way,
    input  logic [TAG_W-1:0]       inst_tag,
    input  logic                   inst_writable,
    input  logic                   inst_prefetched,
    input  logic                   inst_compressed,
    input  logic [BLK_BYTES*8-1:0] inst_data,
    output logic                   resp_valid,
    output logic                   resp_hit,
    output logic                   resp_satisfied,
    output logic                   resp_sc_ok,
    output logic                   resp_range_err,
    output logic                   resp_pf_notify,
    output logic                   resp_dirty,
    output logic [LAT_W-1:0]       resp_lat,
    output logic [ACC_BYTES*8-1:0] resp_rdata
);

    localparam int CNT_W = OFF_W + 2;

    ctl_state_t state_q, state_d;

    logic [ADDR_W-1:0]      rq_addr;
    logic                   rq_write;
    logic [1:0]             rq_size;
    logic                   rq_locked;
    logic [ACC_BYTES*8-1:0] rq_wdata;

    logic [OFF_W-1:0] rq_off;
    logic [IDX_W-1:0] rq_set;
    logic [TAG_W-1:0] rq_tag;
    logic [CNT_W-1:0] nbytes;
    logic [CNT_W-1:0] end_pos;
    logic             range_bad;

    logic [WAYS-1:0][TAG_W-1:0]       rd_tag;
    line_flags_t [WAYS-1:0]           rd_flags;
    logic [WAYS-1:0][BLK_BYTES*8-1:0] rd_data;
    logic [WAYS-1:0]                  way_valid;
    logic                             any_match;
    logic [WAY_W-1:0]                 sel_way;

    line_flags_t            cur_flags, new_flags, inst_flags;
    logic [BLK_BYTES*8-1:0] cur_data, merged;
    logic [ACC_BYTES*8-1:0] ext_rdata;

    logic accept, inst_en, is_sc, perm_ok, lk_hit, do_store, sc_miss, upd_en;
    logic [LAT_W-1:0] lat_c;

    assign req_ready = (state_q == ST_IDLE) && !inst_valid;
    assign accept    = req_valid && req_ready;
    assign inst_en   = inst_valid && (state_q == ST_IDLE);

    // Address fields and range check.
    assign rq_off    = rq_addr[OFF_W-1:0];
    assign rq_set    = rq_addr[OFF_W +: IDX_W];
    assign rq_tag    = rq_addr[ADDR_W-1 -: TAG_W];
    assign nbytes    = CNT_W'(1) << rq_size;
    assign end_pos   = CNT_W'(rq_off) + nbytes;
    assign range_bad = (nbytes > CNT_W'(ACC_BYTES)) || (end_pos > CNT_W'(BLK_BYTES));

    assign inst_flags = '{valid: 1'b1, writable: inst_writable, dirty: 1'b0,
                          pref: inst_prefetched, comp: inst_compressed, resv: 1'b0};

    hpc_line_store #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .BLK_BYTES(BLK_BYTES),
        .IDX_W(IDX_W), .WAY_W(WAY_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .inst_en(inst_en), .inst_set(inst_set), .inst_way(inst_way),
        .inst_tag(inst_tag), .inst_flags(inst_flags), .inst_data(inst_data),
        .upd_en(upd_en), .upd_set(rq_set), .upd_way(sel_way),
        .upd_flags(new_flags), .upd_data(do_store ? merged : cur_data),
        .rd_set(rq_set), .rd_tag(rd_tag), .rd_flags(rd_flags), .rd_data(rd_data)
    );

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_vld
            assign way_valid[w] = rd_flags[w].valid;
        end
    endgenerate

    hpc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
        .way_tag(rd_tag), .way_valid(way_valid), .look_tag(rq_tag),
        .any_match(any_match), .sel_way(sel_way)
    );

    assign cur_flags = rd_flags[sel_way];
    assign cur_data  = rd_data[sel_way];

    hpc_byte_lane #(.BLK_BYTES(BLK_BYTES), .ACC_BYTES(ACC_BYTES), .OFF_W(OFF_W)) u_lane (
        .line(cur_data), .off(rq_off), .nbytes(nbytes), .wdata(rq_wdata),
        .rdata(ext_rdata), .merged(merged)
    );

    // Permission and reservation decisions.
    always_comb begin
        is_sc    = rq_write && rq_locked;
        perm_ok  = rq_write ? cur_flags.writable : 1'b1;
        lk_hit   = !range_bad && any_match && perm_ok;
        do_store = lk_hit && rq_write && (!rq_locked || cur_flags.resv);
        sc_miss  = is_sc && !any_match && !range_bad;
        upd_en   = (state_q == ST_LOOK) && lk_hit;

        new_flags      = cur_flags;
        new_flags.pref = 1'b0;
        if (lk_hit && !rq_write && rq_locked) new_flags.resv = 1'b1;
        if (do_store) begin
            new_flags.dirty = 1'b1;
            new_flags.resv  = 1'b0;
        end

        lat_c = LAT_W'(HIT_LAT);
        if (lk_hit && cur_flags.comp) lat_c = lat_c + LAT_W'(DECOMP_LAT / 4);
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_LOOK;
            ST_LOOK: state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq_addr   <= '0;
            rq_write  <= 1'b0;
            rq_size   <= '0;
            rq_locked <= 1'b0;
            rq_wdata  <= '0;
        end else if (accept) begin
            rq_addr   <= req_addr;
            rq_write  <= req_write;
            rq_size   <= req_size;
            rq_locked <= req_locked;
            rq_wdata  <= req_wdata;
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid     <= 1'b0;
            resp_hit       <= 1'b0;
            resp_satisfied <= 1'b0;
            resp_sc_ok     <= 1'b0;
            resp_range_err <= 1'b0;
            resp_pf_notify <= 1'b0;
            resp_dirty     <= 1'b0;
            resp_lat       <= '0;
            resp_rdata     <= '0;
        end else begin
            resp_valid     <= 1'b0;
            resp_pf_notify <= 1'b0;
            if (state_q == ST_LOOK) begin
                resp_valid     <= 1'b1;
                resp_hit       <= lk_hit;
                resp_satisfied <= lk_hit || sc_miss;
                resp_sc_ok     <= do_store && rq_locked;
                resp_range_err <= range_bad;
                resp_pf_notify <= lk_hit && cur_flags.pref && TRAIN_ON_MISS;
                resp_dirty     <= lk_hit && new_flags.dirty;
                resp_lat       <= lat_c;
                resp_rdata     <= (lk_hit && !rq_write) ? ext_rdata : '0;
            end
        end
    end

endmodule

// File: rtl/cache_hit_check_sva.sv
module cache_hit_check_sva #(
    parameter int HIT_LAT = 2,
    parameter int LAT_W   = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             resp_valid,
    input logic             resp_hit,
    input logic             resp_satisfied,
    input logic             resp_sc_ok,
    input logic             resp_range_err,
    input logic             resp_pf_notify,
    input logic             resp_dirty,
    input logic [LAT_W-1:0] resp_lat
);

    p_resp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    p_accept_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ##1 resp_valid);

    p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_store_dirty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_sc_ok) |-> (resp_hit && resp_dirty));

    p_miss_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> (resp_lat == LAT_W'(HIT_LAT)));

    p_pf_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_pf_notify |-> (resp_valid && resp_hit));

    p_sc_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_satisfied && !resp_hit) |-> (!resp_sc_ok && !resp_range_err && !resp_dirty));

    p_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_range_err) |-> (!resp_hit && !resp_satisfied));

endmodule

bind cache_hit_check cache_hit_check_sva #(.HIT_LAT(HIT_LAT), .LAT_W(LAT_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_satisfied(resp_satisfied),
    .resp_sc_ok(resp_sc_ok), .resp_range_err(resp_range_err),
    .resp_pf_notify(resp_pf_notify), .resp_dirty(resp_dirty), .resp_lat(resp_lat)
);

// File: tb/cache_hit_check_bench.sv
module cache_hit_check_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HIT_LAT    = 2;
    localparam int DECOMP_LAT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0, req_locked = 1'b0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        inst_valid = 1'b0;
    logic [1:0]  inst_set = '0;
    logic        inst_way = 1'b0;
    logic [10:0] inst_tag = '0;
    logic        inst_writable = 1'b0, inst_prefetched = 1'b0, inst_compressed = 1'b0;
    logic [63:0] inst_data = '0;
    logic        resp_valid, resp_hit, resp_satisfied, resp_sc_ok;
    logic        resp_range_err, resp_pf_notify, resp_dirty;
    logic [7:0]  resp_lat;
    logic [31:0] resp_rdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Reference model state.
    logic [10:0] m_tag [4][2];
    logic [63:0] m_dat [4][2];
    bit m_v[4][2], m_w[4][2], m_d[4][2], m_p[4][2], m_c[4][2], m_r[4][2];

    bit e_hit, e_sat, e_sc, e_rng, e_pf, e_dirty;
    logic [7:0]  e_lat;
    logic [31:0] e_rdata;

    cache_hit_check #(.HIT_LAT(HIT_LAT), .DECOMP_LAT(DECOMP_LAT)) u_cache_hit_check (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_size(req_size),
        .req_locked(req_locked), .req_wdata(req_wdata), .inst_valid(inst_valid),
        .inst_set(inst_set), .inst_way(inst_way), .inst_tag(inst_tag),
        .inst_writable(inst_writable), .inst_prefetched(inst_prefetched),
        .inst_compressed(inst_compressed), .inst_data(inst_data),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_satisfied(resp_satisfied),
        .resp_sc_ok(resp_sc_ok), .resp_range_err(resp_range_err),
        .resp_pf_notify(resp_pf_notify), .resp_dirty(resp_dirty),
        .resp_lat(resp_lat), .resp_rdata(resp_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int tag, input int set, input int off);
        return {11'(tag), 2'(set), 3'(off)};
    endfunction

    // Expected response from the requirements; updates the model.
    task automatic model_access(input logic [15:0] a, input bit wr, input int sz,
                                input bit lk, input logic [31:0] wd);
        int off = int'(a[2:0]);
        int s   = int'(a[4:3]);
        int nb  = 1 << sz;
        int w   = -1;
        bit bad, resv0;
        bad = (sz == 3) || (off + nb > 8);
        for (int k = 1; k >= 0; k--) if (m_v[s][k] && m_tag[s][k] == a[15:5]) w = k;
        e_rng = bad;
        e_hit = !bad && (w >= 0) && (!wr || m_w[s][w]);
        e_sat = e_hit || (wr && lk && w < 0 && !bad);
        e_sc = 1'b0; e_pf = 1'b0; e_dirty = 1'b0; e_rdata = '0;
        e_lat = 8'(HIT_LAT);
        if (e_hit) begin
            resv0 = m_r[s][w];
            if (m_c[s][w]) e_lat = 8'(HIT_LAT + DECOMP_LAT/4);
            e_pf = m_p[s][w];
            m_p[s][w] = 1'b0;
            if (!wr) begin
                for (int i = 0; i < nb; i++) e_rdata[i*8 +: 8] = m_dat[s][w][(off+i)*8 +: 8];
                if (lk) m_r[s][w] = 1'b1;
            end else if (!lk || resv0) begin
                for (int i = 0; i < nb; i++) m_dat[s][w][(off+i)*8 +: 8] = wd[i*8 +: 8];
                m_d[s][w] = 1'b1;
                m_r[s][w] = 1'b0;
                e_sc = lk;
            end
            e_dirty = m_d[s][w];
        end
    endtask

    task automatic do_install(input int s, input int w, input int tag, input bit wrt,
                              input bit pf, input bit cp, input logic [63:0] d);
        @(negedge clk);
        inst_valid = 1'b1; inst_set = 2'(s); inst_way = 1'(w); inst_tag = 11'(tag);
        inst_writable = wrt; inst_prefetched = pf; inst_compressed = cp; inst_data = d;
        #1;
        check_eq("R12 ready low during install", 64'(req_ready), 64'd0);
        @(negedge clk);
        inst_valid = 1'b0;
        m_tag[s][w] = 11'(tag); m_dat[s][w] = d;
        m_v[s][w] = 1'b1; m_w[s][w] = wrt; m_p[s][w] = pf; m_c[s][w] = cp;
        m_d[s][w] = 1'b0; m_r[s][w] = 1'b0;
    endtask

    task automatic do_req(input logic [15:0] a, input bit wr, input int sz,
                          input bit lk, input logic [31:0] wd);
        model_access(a, wr, sz, lk, wd);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_size = 2'(sz);
        req_locked = lk; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check_eq("R2 ready low after accept", 64'(req_ready), 64'd0);
        @(negedge clk);
        check_eq("R2 resp_valid", 64'(resp_valid), 64'd1);
        check_eq("R3/R4 hit", 64'(resp_hit), 64'(e_hit));
        check_eq("R8 satisfied", 64'(resp_satisfied), 64'(e_sat));
        check_eq("R9/R10 sc_ok", 64'(resp_sc_ok), 64'(e_sc));
        check_eq("R11 range_err", 64'(resp_range_err), 64'(e_rng));
        check_eq("R7 pf_notify", 64'(resp_pf_notify), 64'(e_pf));
        check_eq("R5 dirty", 64'(resp_dirty), 64'(e_dirty));
        check_eq("R6 latency", 64'(resp_lat), 64'(e_lat));
        check_eq("R3 rdata", 64'(resp_rdata), 64'(e_rdata));
        @(negedge clk);
        check_eq("R2 single-cycle resp", 64'(resp_valid), 64'd0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'h5eed_c0de);
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 2; w++) begin
                m_v[s][w] = 0; m_w[s][w] = 0; m_d[s][w] = 0;
                m_p[s][w] = 0; m_c[s][w] = 0; m_r[s][w] = 0;
                m_tag[s][w] = '0; m_dat[s][w] = '0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state and empty arrays.
        check_eq("R1 ready after reset", 64'(req_ready), 64'd1);
        check_eq("R1 no resp after reset", 64'(resp_valid), 64'd0);
        do_req(mk(0, 0, 0), 0, 2, 0, 0);

        // R3: read sizes and offsets.
        do_install(1, 0, 5, 1, 0, 0, 64'h8877_6655_4433_2211);
        do_req(mk(5, 1, 0), 0, 2, 0, 0);
        do_req(mk(5, 1, 6), 0, 1, 0, 0);
        do_req(mk(5, 1, 7), 0, 0, 0, 0);
        // R11: overrun and invalid size code.
        do_req(mk(5, 1, 6), 0, 2, 0, 0);
        do_req(mk(5, 1, 0), 0, 3, 0, 0);
        do_req(mk(5, 1, 5), 1, 2, 1, 32'hdead_beef);
        // R4: write to read-only line.
        do_install(2, 1, 7, 0, 0, 0, 64'h0102_0304_0506_0708);
        do_req(mk(7, 2, 0), 1, 2, 0, 32'hffff_ffff);
        do_req(mk(7, 2, 0), 0, 2, 0, 0);
        // R5: write merge then read back.
        do_req(mk(5, 1, 2), 1, 1, 0, 32'h0000_abcd);
        do_req(mk(5, 1, 0), 0, 2, 0, 0);
        // R6: compressed line latency.
        do_install(3, 0, 9, 1, 0, 1, 64'h1111_2222_3333_4444);
        do_req(mk(9, 3, 4), 0, 2, 0, 0);
        // R7: prefetch notification is one-shot.
        do_install(0, 1, 4, 1, 1, 0, 64'h0f0e_0d0c_0b0a_0908);
        do_req(mk(4, 0, 0), 0, 0, 0, 0);
        do_req(mk(4, 0, 0), 0, 0, 0, 0);
        // R8: store-conditional with no match.
        do_req(mk(30, 3, 0), 1, 2, 1, 32'h1234_5678);
        // R9: load-linked then store-conditional succeeds.
        do_req(mk(5, 1, 4), 0, 2, 1, 0);
        do_req(mk(5, 1, 4), 1, 2, 1, 32'hcafe_f00d);
        // R10: repeated SC fails; plain write breaks reservation.
        do_req(mk(5, 1, 4), 1, 2, 1, 32'h0bad_0bad);
        do_req(mk(5, 1, 0), 0, 2, 1, 0);
        do_req(mk(5, 1, 0), 1, 0, 0, 32'h0000_0077);
        do_req(mk(5, 1, 0), 1, 2, 1, 32'h7777_7777);
        do_req(mk(5, 1, 0), 0, 2, 0, 0);

        // Seeded random mix over a small tag pool.
        for (int k = 0; k < 600; k++) begin
            int r = int'($urandom % 10);
            if (r < 2) begin
                do_install(int'($urandom % 4), int'($urandom % 2), 1 + int'($urandom % 3),
                           1'($urandom), 1'($urandom), 1'($urandom), {$urandom, $urandom});
            end else begin
                do_req(mk(1 + int'($urandom % 4), int'($urandom % 4), int'($urandom % 8)),
                       1'($urandom), int'($urandom % 4), ($urandom % 3) == 0, $urandom);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule